// File: doc/BRIEF.md
# Bidirectional Cascaded Line Loader

This block collects one display line of grey-level codes for a column driver and presents it, complete, to the conversion stage. A driver owns a fixed number of column outputs, and a long panel row is split across several such drivers wired in a chain. A start pulse enters the first driver. That driver takes one pixel per clock, and each pixel carries three colour codes that land on three neighbouring outputs. When it has taken its last pixel, it passes a start pulse to the next driver so that the next one takes the very next pixel with no gap.

A strap input sets the fill direction. With the strap high, filling runs from the lowest-numbered output upward, and enable pin 1 listens while enable pin 2 talks. With the strap low, filling runs from the highest output downward and the two pins swap roles. Each pin is split into an input, an output and an output-enable, so the pad ring can build the bidirectional pad. The rising edge of a load strobe copies the whole filled buffer into a holding register. That register feeds the converters while the next line is loading.

Top module: `line_loader`

## Requirements
- R1: After synchronous reset, line_o is all zero, en1_o and en2_o are low, and no loading is in progress.
- R2: With dir_up = 1, en1_oe = 0 and en2_oe = 1. With dir_up = 0, en1_oe = 1 and en2_oe = 0.
- R3: A loading run starts when the listening enable pin (en1_i if dir_up = 1, else en2_i) is sampled high at a clock edge after being sampled low at the previous edge. The pixels sampled at the next NUM_OUT/3 edges are stored. A pulse on the talking pin's input is ignored.
- R4: With dir_up = 1, pixel k (counting from 0) puts bits [6j+5:6j] of pix_i on output 3k+j (0-based, j = 0..2). Output n occupies line_o[6n+5:6n].
- R5: With dir_up = 0, pixel k puts bits [6j+5:6j] of pix_i on output NUM_OUT-1-3k-j.
- R6: In each run, the talking enable output is high for exactly one clock period. That period begins at the edge that stores the second-to-last pixel. The listening pin's output stays low.
- R7: A start pulse held high for two clock periods starts a single run.
- R8: Pixels presented while no run is active (before a start, or after the line is full) change nothing that a later load copies.
- R9: line_o takes the buffer contents only at an edge where load_i is sampled high after being sampled low. line_o does not change while load_i stays high, even when a new line fills underneath.
- R10: A rising edge on the listening pin during a run neither restarts nor shifts that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| dir_up | input | 1 | Fill direction strap: 1 = upward from output 0 |
| en1_i | input | 1 | Enable pin 1, pad input side |
| en1_o | output | 1 | Enable pin 1, pad output side |
| en1_oe | output | 1 | Enable pin 1, output enable |
| en2_i | input | 1 | Enable pin 2, pad input side |
| en2_o | output | 1 | Enable pin 2, pad output side |
| en2_oe | output | 1 | Enable pin 2, output enable |
| pix_i | input | 3*PIX_W | One pixel: three grey codes, field 0 in the low bits |
| load_i | input | 1 | Load strobe; its rising edge latches the line |
| line_o | output | NUM_OUT*PIX_W | Held line, output n at bits [PIX_W*n +: PIX_W] |

## Verification
The hardest case to reach is the cascade hand-off. The outgoing pulse must land exactly one period before the last pixel, and only on the talking pin, and it must stay that way when a second start edge arrives mid-run or the start pulse is two periods wide. The stimulus runs whole lines in both directions. It samples both enable outputs at every pixel, records how many times and at which pixel index the talking pin was high, and compares that index with the last-but-one pixel. Held-load and idle-pixel scenarios load again afterwards, so that any stray write becomes visible on line_o.

// File: rtl/line_loader_pkg.sv
package line_loader_pkg;
  localparam int COLORS = 3;

  typedef enum logic {ST_IDLE, ST_FILL} fill_state_e;
endpackage

// File: rtl/line_loader_ctrl.sv
module line_loader_ctrl
  import line_loader_pkg::*;
#(
  parameter int NUM_SLOTS = 160,
  localparam int CW = $clog2(NUM_SLOTS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dir_up,
  input  logic          en1_i,
  input  logic          en2_i,
  output logic          en1_o,
  output logic          en2_o,
  output logic          wr_en,
  output logic [CW-1:0] wr_slot
);
  localparam logic [CW-1:0] LAST      = CW'(NUM_SLOTS - 1);
  localparam logic [CW-1:0] NEXT_LAST = CW'(NUM_SLOTS - 2);

  fill_state_e   st;
  logic [CW-1:0] cnt;
  logic          en_prev;
  logic          en1_q, en2_q;
  logic          en_in;

  assign en_in = dir_up ? en1_i : en2_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      en_prev <= 1'b0;
      en1_q   <= 1'b0;
      en2_q   <= 1'b0;
    end else begin
      en_prev <= en_in;
      en1_q   <= 1'b0;
      en2_q   <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (en_in && !en_prev) begin
            st  <= ST_FILL;
            cnt <= '0;
          end
        end
        ST_FILL: begin
          cnt <= cnt + 1'b1;
          if (cnt == NEXT_LAST) begin
            en1_q <= !dir_up;
            en2_q <= dir_up;
          end
          if (cnt == LAST) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign wr_en   = (st == ST_FILL);
  assign wr_slot = dir_up ? cnt : (LAST - cnt);
  assign en1_o   = en1_q;
  assign en2_o   = en2_q;

  // R6
  cascade_width_chk: assert property (@(posedge clk) disable iff (rst)
    (en1_o || en2_o) |=> !(en1_o || en2_o));

  // R6
  cascade_place_chk: assert property (@(posedge clk) disable iff (rst)
    (en1_o || en2_o) |-> (st == ST_FILL && cnt == LAST));

  // R6
  cascade_pin_chk: assert property (@(posedge clk) disable iff (rst)
    !(en1_o && en2_o));

  // R3
  run_length_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_FILL && cnt != LAST) |=> (st == ST_FILL));
endmodule

// File: rtl/line_loader_buf.sv
module line_loader_buf
  import line_loader_pkg::*;
#(
  parameter int NUM_SLOTS = 160,
  parameter int PIX_W     = 6,
  localparam int CW       = $clog2(NUM_SLOTS),
  localparam int SLOT_W   = COLORS * PIX_W,
  localparam int LINE_W   = NUM_SLOTS * SLOT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dir_up,
  input  logic              wr_en,
  input  logic [CW-1:0]     wr_slot,
  input  logic [SLOT_W-1:0] pix_i,
  input  logic              load_i,
  output logic [LINE_W-1:0] line_o
);
  logic [SLOT_W-1:0] pix_ord;
  logic [SLOT_W-1:0] slot_q [NUM_SLOTS];
  logic [LINE_W-1:0] line_q;
  logic              load_prev;
  logic              load_edge;

  // downward fill mirrors the colour order inside each triplet
  for (genvar j = 0; j < COLORS; j++) begin : g_ord
    assign pix_ord[j*PIX_W +: PIX_W] =
      dir_up ? pix_i[j*PIX_W +: PIX_W] : pix_i[(COLORS-1-j)*PIX_W +: PIX_W];
  end

  always_ff @(posedge clk) begin
    if (wr_en) slot_q[wr_slot] <= pix_ord;
  end

  always_ff @(posedge clk) begin
    if (rst) load_prev <= 1'b0;
    else     load_prev <= load_i;
  end

  assign load_edge = load_i && !load_prev;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_hold
    always_ff @(posedge clk) begin
      if (rst)            line_q[s*SLOT_W +: SLOT_W] <= '0;
      else if (load_edge) line_q[s*SLOT_W +: SLOT_W] <= slot_q[s];
    end
  end

  assign line_o = line_q;

  // R4
  slot_range_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (32'(wr_slot) < NUM_SLOTS));

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !load_edge |=> $stable(line_q));
endmodule

// File: rtl/line_loader.sv
module line_loader
  import line_loader_pkg::*;
#(
  parameter int NUM_OUT = 480,
  parameter int PIX_W   = 6,
  localparam int NUM_SLOTS = NUM_OUT / COLORS,
  localparam int CW        = $clog2(NUM_SLOTS)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      dir_up,
  input  logic                      en1_i,
  output logic                      en1_o,
  output logic                      en1_oe,
  input  logic                      en2_i,
  output logic                      en2_o,
  output logic                      en2_oe,
  input  logic [COLORS*PIX_W-1:0]   pix_i,
  input  logic                      load_i,
  output logic [NUM_OUT*PIX_W-1:0]  line_o
);
  logic          wr_en;
  logic [CW-1:0] wr_slot;

  assign en1_oe = !dir_up;
  assign en2_oe = dir_up;

  line_loader_ctrl #(.NUM_SLOTS(NUM_SLOTS)) ctrl_i (
    .clk     (clk),
    .rst     (rst),
    .dir_up  (dir_up),
    .en1_i   (en1_i),
    .en2_i   (en2_i),
    .en1_o   (en1_o),
    .en2_o   (en2_o),
    .wr_en   (wr_en),
    .wr_slot (wr_slot)
  );

  line_loader_buf #(.NUM_SLOTS(NUM_SLOTS), .PIX_W(PIX_W)) buf_i (
    .clk     (clk),
    .rst     (rst),
    .dir_up  (dir_up),
    .wr_en   (wr_en),
    .wr_slot (wr_slot),
    .pix_i   (pix_i),
    .load_i  (load_i),
    .line_o  (line_o)
  );

  // R2
  pin_role_chk: assert property (@(posedge clk) disable iff (rst)
    (en1_oe != en2_oe) && !(en1_o && !en1_oe) && !(en2_o && !en2_oe));
endmodule

// File: tb/line_loader_tb_top.sv
module line_loader_tb_top;
  localparam int NO = 480;
  localparam int PW = 6;
  localparam int NS = NO / 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dir_up = 1'b1;
  logic en1_i = 1'b0, en2_i = 1'b0;
  logic en1_o, en1_oe, en2_o, en2_oe;
  logic [3*PW-1:0] pix = '0;
  logic load = 1'b0;
  logic [NO*PW-1:0] line_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [PW-1:0] expv [NO];

  always #10 clk = ~clk;

  line_loader #(.NUM_OUT(NO), .PIX_W(PW)) dut_i (
    .clk(clk), .rst(rst), .dir_up(dir_up),
    .en1_i(en1_i), .en1_o(en1_o), .en1_oe(en1_oe),
    .en2_i(en2_i), .en2_o(en2_o), .en2_oe(en2_oe),
    .pix_i(pix), .load_i(load), .line_o(line_o)
  );

  function automatic logic [3*PW-1:0] mkpix(input int k, input int seed);
    return {PW'(k*7 + seed + 5), PW'(k*5 + seed + 3), PW'(k*3 + seed + 1)};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_line(input string req);
    int bad = 0, first = -1;
    for (int n = 0; n < NO; n++)
      if (line_o[n*PW +: PW] !== expv[n]) begin
        bad++;
        if (first < 0) first = n;
      end
    if (first < 0) check(1'b1, req, "line", 0, 0);
    else check(1'b0, req, $sformatf("line output %0d", first),
               int'(line_o[first*PW +: PW]), int'(expv[first]));
  endtask

  task automatic set_listen(input bit up, input bit v);
    if (up) en1_i = v; else en2_i = v;
  endtask

  // Fills one line; checks the cascade pulse (R6) and records the expected buffer.
  task automatic run_line(input bit up, input int seed, input int en_len,
                          input bit mid, input string req);
    int hi_cnt = 0, hi_at = -1;
    bit other_hi = 1'b0;
    @(negedge clk);
    dir_up = up;
    set_listen(up, 1'b1);
    @(negedge clk);
    for (int k = 0; k < NS; k++) begin
      if (k > 0) @(negedge clk);
      if (up ? en2_o : en1_o) begin hi_cnt++; hi_at = k; end
      if (up ? en1_o : en2_o) other_hi = 1'b1;
      pix = mkpix(k, seed);
      set_listen(up, (k == 0 && en_len == 2) || (mid && k == 50));
    end
    @(negedge clk);
    if (up ? en2_o : en1_o) hi_cnt++;
    if (up ? en1_o : en2_o) other_hi = 1'b1;
    set_listen(up, 1'b0);
    check(hi_cnt == 1, {"R6 ", req}, "cascade pulse count", hi_cnt, 1);
    check(hi_at == NS - 1, {"R6 ", req}, "cascade pulse pixel", hi_at, NS - 1);
    check(!other_hi, {"R6 ", req}, "listening pin output", int'(other_hi), 0);
    for (int k = 0; k < NS; k++) begin
      logic [3*PW-1:0] p = mkpix(k, seed);
      for (int j = 0; j < 3; j++)
        expv[up ? 3*k + j : NO - 1 - 3*k - j] = p[j*PW +: PW];
    end
  endtask

  task automatic do_load();
    @(negedge clk); load = 1'b1;
    @(negedge clk); load = 1'b0;
  endtask

  task automatic t_reset();
    check(line_o == '0, "R1", "line after reset", int'(line_o[PW-1:0]), 0);
    check(!en1_o && !en2_o, "R1", "enable outputs", int'({en1_o, en2_o}), 0);
    dir_up = 1'b1; #1;
    check(!en1_oe && en2_oe, "R2", "oe up", int'({en1_oe, en2_oe}), 1);
    dir_up = 1'b0; #1;
    check(en1_oe && !en2_oe, "R2", "oe down", int'({en1_oe, en2_oe}), 2);
    dir_up = 1'b1;
  endtask

  task automatic t_up();
    run_line(1'b1, 11, 1, 1'b0, "up");
    do_load();
    check_line("R4");
  endtask

  task automatic t_down();
    run_line(1'b0, 29, 1, 1'b0, "down");
    do_load();
    check_line("R5");
  endtask

  task automatic t_wide_start();
    run_line(1'b1, 40, 2, 1'b0, "wide start R7");
    do_load();
    check_line("R7");
  endtask

  task automatic t_mid_start();
    run_line(1'b0, 3, 1, 1'b1, "mid start R10");
    do_load();
    check_line("R10");
  endtask

  task automatic t_ignore();
    // idle pixels, then a pulse on the talking pin, then more pixels
    dir_up = 1'b1;
    for (int k = 0; k < 20; k++) begin @(negedge clk); pix = mkpix(k, 50); end
    @(negedge clk); en2_i = 1'b1;
    @(negedge clk); en2_i = 1'b0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk); pix = mkpix(k, 60);
      if (en1_o || en2_o)
        check(1'b0, "R3", "cascade from talking-pin pulse", 1, 0);
    end
    do_load();
    check_line("R8");
    check_line("R3");
  endtask

  task automatic t_hold();
    logic [PW-1:0] keep [NO];
    run_line(1'b1, 17, 1, 1'b0, "hold A");
    @(negedge clk); load = 1'b1;
    @(negedge clk);
    check_line("R9");
    keep = expv;
    run_line(1'b0, 23, 1, 1'b0, "hold B");
    expv = keep;
    check_line("R9");
    run_line(1'b0, 23, 1, 1'b0, "hold B2");
    @(negedge clk); load = 1'b0;
    @(negedge clk); load = 1'b1;
    @(negedge clk); load = 1'b0;
    check_line("R9");
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_up();
    t_down();
    t_wide_start();
    t_mid_start();
    t_ignore();
    t_hold();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule